// File: doc/BRIEF.md
# Scan and Word Timing Generator

This block paces the frame timing of a demultiplexer sequencer. A port counter moves forward by one on every port-slot strobe. A 5-bit setting gives the number of ports in use, which is the length of a scan. When the counter reaches that length, the block marks the end of the scan on a true output and on its complement. On the next slot the counter reloads to 1, and the word counter moves on to the next word.

Two decoded marks come from the same end-of-scan event. The first is an early-warning strobe that fires when the scan ends during word 23. The second is a final-word strobe that fires when the scan ends during word 29, and it times a downstream CRC stage. Every output comes straight from a flip-flop.

Top module: `swt_scan_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `port_cnt`=0, `word_cnt`=0, `eos`=0, `eos_n`=1, `w24_stb`=0 and `w29_eos_stb`=0.
- R2: On a clock edge where `slot_stb` is high and `port_cnt` is below the effective scan length, `port_cnt` increases by 1. On an edge where `slot_stb` is low, `port_cnt` and `word_cnt` hold their values.
- R3: `eos` is high for exactly the one cycle after a slot that brings `port_cnt` to the effective scan length, and low at all other times. `eos_n` is always the inverse of `eos`.
- R4: On the slot that follows the one where the scan length was reached, `port_cnt` reloads to 1.
- R5: `word_cnt` increases by 1 on each reload of `port_cnt`, and wraps from 29 to 0. Before the first reload after reset it stays at 0.
- R6: A `ports_in_use` value of 0 gives an effective scan length of 1, so every slot ends a scan. Any other value is used as it is.
- R7: `w24_stb` is high exactly when `eos` is high and `word_cnt` is 23.
- R8: `w29_eos_stb` is high exactly when `eos` is high and `word_cnt` is 29.
- R9: If `ports_in_use` drops below the current `port_cnt`, the next slot reloads `port_cnt` to 1, advances `word_cnt`, and raises no `eos` unless the new length is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slot_stb | input | 1 | One-cycle strobe for each port slot |
| ports_in_use | input | 5 | Configured scan length in ports (0 is treated as 1) |
| port_cnt | output | 5 | Current port position within the scan |
| word_cnt | output | 5 | Current word number, 0 to 29 |
| eos | output | 1 | End-of-scan mark, true polarity |
| eos_n | output | 1 | End-of-scan mark, complement polarity |
| w24_stb | output | 1 | Early-warning strobe: end of scan during word 23 |
| w29_eos_stb | output | 1 | Final-word strobe: end of scan during word 29 |

## Verification
The first pattern sends slots back to back at a fixed length of 5 for long enough to wrap the word counter more than once. This confirms the reload point, the 29-to-0 wrap, and that each word strobe fires once per word cycle. The second pattern sends sparse, random slots, which shows that the counters hold between strobes and that `eos` is a single-cycle pulse rather than a level. Lengths of 0 and 1 separate the zero-as-one rule from a stall. A length cut mid-scan below the current count, plus random length changes, checks that a count which has passed its limit still reloads.

// File: rtl/swt_pkg.sv
package swt_pkg;
  typedef struct packed {
    logic eos;
    logic eos_n;
    logic early;
    logic last;
  } swt_marks_t;

  localparam swt_marks_t SWT_MARKS_IDLE = '{eos: 1'b0, eos_n: 1'b1, early: 1'b0, last: 1'b0};
endpackage

// File: rtl/swt_port_ctr.sv
module swt_port_ctr #(
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          slot_stb,
  input  logic [PW-1:0] limit_raw,
  output logic [PW-1:0] port_cnt,
  output logic          wrap,
  output logic          hit
);
  localparam logic [PW-1:0] ONE = PW'(1);

  logic [PW-1:0] limit_eff;
  logic [PW-1:0] port_nxt;

  // a zero setting would never match the counter, so it becomes one
  assign limit_eff = (limit_raw == '0) ? ONE : limit_raw;

  always_comb begin
    wrap     = slot_stb && (port_cnt >= limit_eff);
    port_nxt = wrap ? ONE : port_cnt + ONE;
    hit      = slot_stb && (port_nxt == limit_eff);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      port_cnt <= '0;
    end else if (slot_stb) begin
      port_cnt <= port_nxt;
    end
  end
endmodule

// File: rtl/swt_word_ctr.sv
module swt_word_ctr #(
  parameter int WW        = 5,
  parameter int WORD_LAST = 29
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [WW-1:0] word_cnt,
  output logic [WW-1:0] word_nxt
);
  localparam logic [WW-1:0] LAST_W = WW'(WORD_LAST);

  always_comb begin
    word_nxt = word_cnt;
    if (adv) begin
      word_nxt = (word_cnt == LAST_W) ? '0 : word_cnt + WW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_cnt <= '0;
    end else begin
      word_cnt <= word_nxt;
    end
  end
endmodule

// File: rtl/swt_mark_gen.sv
module swt_mark_gen
  import swt_pkg::*;
#(
  parameter int WW         = 5,
  parameter int EARLY_WORD = 23,
  parameter int FINAL_WORD = 29
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit,
  input  logic [WW-1:0] word_nxt,
  output swt_marks_t    marks
);
  localparam logic [WW-1:0] EARLY_W = WW'(EARLY_WORD);
  localparam logic [WW-1:0] FINAL_W = WW'(FINAL_WORD);

  swt_marks_t marks_d;

  // decode against the word value that will be shown next to the mark
  always_comb begin
    marks_d.eos   = hit;
    marks_d.eos_n = ~hit;
    marks_d.early = hit && (word_nxt == EARLY_W);
    marks_d.last  = hit && (word_nxt == FINAL_W);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      marks <= SWT_MARKS_IDLE;
    end else begin
      marks <= marks_d;
    end
  end
endmodule

// File: rtl/swt_scan_timer.sv
module swt_scan_timer
  import swt_pkg::*;
#(
  parameter int PW         = 5,
  parameter int WW         = 5,
  parameter int WORD_LAST  = 29,
  parameter int EARLY_WORD = 23,
  parameter int FINAL_WORD = 29
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          slot_stb,
  input  logic [PW-1:0] ports_in_use,
  output logic [PW-1:0] port_cnt,
  output logic [WW-1:0] word_cnt,
  output logic          eos,
  output logic          eos_n,
  output logic          w24_stb,
  output logic          w29_eos_stb
);
  logic          wrap;
  logic          hit;
  logic [WW-1:0] word_nxt;
  swt_marks_t    marks;

  swt_port_ctr #(.PW(PW)) u_port (
    .clk       (clk),
    .rst       (rst),
    .slot_stb  (slot_stb),
    .limit_raw (ports_in_use),
    .port_cnt  (port_cnt),
    .wrap      (wrap),
    .hit       (hit)
  );

  swt_word_ctr #(.WW(WW), .WORD_LAST(WORD_LAST)) u_word (
    .clk      (clk),
    .rst      (rst),
    .adv      (wrap),
    .word_cnt (word_cnt),
    .word_nxt (word_nxt)
  );

  swt_mark_gen #(.WW(WW), .EARLY_WORD(EARLY_WORD), .FINAL_WORD(FINAL_WORD)) u_mark (
    .clk      (clk),
    .rst      (rst),
    .hit      (hit),
    .word_nxt (word_nxt),
    .marks    (marks)
  );

  assign eos         = marks.eos;
  assign eos_n       = marks.eos_n;
  assign w24_stb     = marks.early;
  assign w29_eos_stb = marks.last;
endmodule

// File: rtl/swt_scan_timer_chk.sv
module swt_scan_timer_chk #(
  parameter int PW         = 5,
  parameter int WW         = 5,
  parameter int WORD_LAST  = 29,
  parameter int EARLY_WORD = 23,
  parameter int FINAL_WORD = 29
) (
  input logic          clk,
  input logic          rst,
  input logic          slot_stb,
  input logic [PW-1:0] ports_in_use,
  input logic [PW-1:0] port_cnt,
  input logic [WW-1:0] word_cnt,
  input logic          eos,
  input logic          eos_n,
  input logic          w24_stb,
  input logic          w29_eos_stb
);
  localparam logic [WW-1:0] LAST_W  = WW'(WORD_LAST);
  localparam logic [WW-1:0] EARLY_W = WW'(EARLY_WORD);
  localparam logic [WW-1:0] FINAL_W = WW'(FINAL_WORD);

  logic [PW-1:0] lim;
  logic          rst_q = 1'b0;

  assign lim = (ports_in_use == '0) ? PW'(1) : ports_in_use;

  always @(posedge clk) rst_q <= rst;

  always @(posedge clk) begin
    if (rst_q) begin
      p_reset_state_r1: assert (port_cnt == '0 && word_cnt == '0 && !eos && eos_n
                                && !w24_stb && !w29_eos_stb);
    end
  end

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    slot_stb && port_cnt < lim |=> port_cnt == $past(port_cnt) + PW'(1));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !slot_stb |=> $stable(port_cnt) && $stable(word_cnt) && !eos);

  p_compl_r3: assert property (@(posedge clk) disable iff (rst)
    eos_n == !eos);

  p_eos_at_limit_r3: assert property (@(posedge clk) disable iff (rst)
    slot_stb && port_cnt == lim - PW'(1) |=> eos);

  p_reload_r4: assert property (@(posedge clk) disable iff (rst)
    slot_stb && port_cnt >= lim |=> port_cnt == PW'(1));

  p_word_step_r5: assert property (@(posedge clk) disable iff (rst)
    slot_stb && port_cnt >= lim && word_cnt != LAST_W |=> word_cnt == $past(word_cnt) + WW'(1));

  p_word_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    slot_stb && port_cnt >= lim && word_cnt == LAST_W |=> word_cnt == '0);

  p_zero_len_r6: assert property (@(posedge clk) disable iff (rst)
    slot_stb && ports_in_use == '0 |=> eos && port_cnt == PW'(1));

  p_early_r7: assert property (@(posedge clk) disable iff (rst)
    w24_stb == (eos && word_cnt == EARLY_W));

  p_final_r8: assert property (@(posedge clk) disable iff (rst)
    w29_eos_stb == (eos && word_cnt == FINAL_W));

  p_shrink_r9: assert property (@(posedge clk) disable iff (rst)
    slot_stb && port_cnt > lim && lim != PW'(1) |=> !eos);
endmodule

bind swt_scan_timer swt_scan_timer_chk #(
  .PW(PW), .WW(WW), .WORD_LAST(WORD_LAST), .EARLY_WORD(EARLY_WORD), .FINAL_WORD(FINAL_WORD)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .slot_stb     (slot_stb),
  .ports_in_use (ports_in_use),
  .port_cnt     (port_cnt),
  .word_cnt     (word_cnt),
  .eos          (eos),
  .eos_n        (eos_n),
  .w24_stb      (w24_stb),
  .w29_eos_stb  (w29_eos_stb)
);

// File: tb/sim_swt_scan_timer.sv
`timescale 1ns/1ps
module sim_swt_scan_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       slot_stb = 1'b0;
  logic [4:0] ports_in_use = 5'd5;
  logic [4:0] port_cnt;
  logic [4:0] word_cnt;
  logic       eos, eos_n, w24_stb, w29_eos_stb;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  string phase = "R2";

  // reference model state
  int mp = 0, mw = 0;
  bit me = 0, m24 = 0, m29 = 0;

  always #4 clk = ~clk;

  swt_scan_timer u0 (
    .clk(clk), .rst(rst), .slot_stb(slot_stb), .ports_in_use(ports_in_use),
    .port_cnt(port_cnt), .word_cnt(word_cnt), .eos(eos), .eos_n(eos_n),
    .w24_stb(w24_stb), .w29_eos_stb(w29_eos_stb)
  );

  always @(posedge clk) begin
    int len;
    len = (ports_in_use == 0) ? 1 : int'(ports_in_use);
    if (rst) begin
      mp = 0; mw = 0; me = 0; m24 = 0; m29 = 0;
    end else if (slot_stb) begin
      if (mp >= len) begin
        mp = 1;
        mw = (mw == 29) ? 0 : mw + 1;
      end else begin
        mp = mp + 1;
      end
      me  = (mp == len);
      m24 = me && (mw == 23);
      m29 = me && (mw == 29);
    end else begin
      me = 0; m24 = 0; m29 = 0;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s (%s) t=%0t actual=%0d expected=%0d", req, phase, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R2 port_cnt", int'(port_cnt), mp);
    chk("R5 word_cnt", int'(word_cnt), mw);
    chk("R3 eos", int'(eos), int'(me));
    chk("R3 eos_n", int'(eos_n), int'(!me));
    chk("R7 w24_stb", int'(w24_stb), int'(m24));
    chk("R8 w29_eos_stb", int'(w29_eos_stb), int'(m29));
  endtask

  task automatic run(int n, int len, int density);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
      ports_in_use = 5'(len);
      slot_stb = (($urandom % 100) < density);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    phase = "R1";
    chk("R1 port_cnt", int'(port_cnt), 0);
    chk("R1 word_cnt", int'(word_cnt), 0);
    chk("R1 eos", int'(eos), 0);
    chk("R1 eos_n", int'(eos_n), 1);
    chk("R1 w24_stb", int'(w24_stb), 0);
    chk("R1 w29_eos_stb", int'(w29_eos_stb), 0);
    rst = 1'b0;

    phase = "R4 R5 back-to-back length 5";
    run(340, 5, 100);
    phase = "R2 sparse length 3";
    run(600, 3, 30);
    phase = "R6 length 0";
    run(80, 0, 100);
    phase = "R6 length 1";
    run(80, 1, 60);

    phase = "R9 shrink";
    while (mp != 4) run(1, 6, 100);
    run(1, 2, 100);
    @(negedge clk);
    chk("R9 port reload", int'(port_cnt), 1);
    chk("R9 no eos", int'(eos), 0);
    compare_all();
    run(40, 2, 100);

    phase = "R9 random lengths";
    for (int k = 0; k < 60; k++) run(25, $urandom % 32, 70);

    phase = "R1 mid-run reset";
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 port_cnt after reset", int'(port_cnt), 0);
    chk("R1 eos_n after reset", int'(eos_n), 1);
    rst = 1'b0;
    run(20, 4, 100);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (%s) actual=hung expected=finished", phase);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule